// File: doc/BRIEF.md
# Edge-Controlled Up/Down Timer

This block is a 16-bit timer counter that counts up or down and runs from one of several count sources. The source can be the peripheral clock divided by a power of two, rising edges of a separate count input, or the wrap pulses of a lower-numbered neighbouring timer. When the counter passes its top value counting up, or passes zero counting down, it wraps and raises a one-cycle wrap pulse. That pulse can clock the next timer in a chain.

An external control input starts, stops or reloads the counter. Its rising and falling edges each have their own two-bit action code. This lets a pulse on the pin gate the counter directly, with no software in the loop. Software sets up the block through a small register port. It can also start and stop the counter by writing a command register.

Top module: `edge_timer`

## Requirements
- R1: After reset, the control register reads 0, the count reads 0, the top value reads 0xFFFF, the counter is stopped and both wrap outputs are low.
- R2: The control register at byte address 0x00 keeps only these fields: divide code in bits 27:24, count source in bits 17:16, falling-edge action in bits 11:10 and rising-edge action in bits 9:8. All other bits read back as 0. The top value is at 0x08 in bits 15:0. The count is at 0x0C in bits 15:0 and is writable. The direction is bit 0 of 0x10, where 1 means down. Reads return the register value one clock edge after the address is presented.
- R3: With count source 0, a counter started at edge s and stopped at edge s+n has advanced by floor(n / 2^min(code,10)). The divide phase restarts at every start. Source code 3 behaves as source 0.
- R4: With count source 1, the counter advances once per rising edge of the count input. That input passes through a two-flop synchroniser, so a level held high counts only once.
- R5: With count source 2, the counter advances once per cycle that the neighbour's overflow input is high when counting up. When counting down, it advances once per cycle that the neighbour's underflow input is high. The other neighbour input is ignored.
- R6: The rising-edge action code means 0 = nothing, 1 = start, 2 = stop, 3 = reload and start. An external-input change driven before edge k takes effect at edge k+2. A stopped counter's value does not change when the code is 0.
- R7: The falling-edge action uses the same codes and acts on falling edges, independently of the rising-edge code.
- R8: Reload and start loads 0 when counting up, or loads the top value when counting down, and sets the counter running at the same edge.
- R9: An edge action that fires in the same cycle as a software command wins over the command.
- R10: Counting up wraps from top to 0 and pulses the overflow output for one cycle. Counting down wraps from 0 to top and pulses the underflow output for one cycle. The two outputs are never high together.
- R11: Writing bit 0 of the command register (0x04) starts the counter and writing bit 1 stops it. Neither changes the count value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 32 | Registered read data |
| ext_in | input | 1 | Asynchronous control input whose edges trigger actions |
| tick_in | input | 1 | Asynchronous count input for source 1 |
| nbr_ovf | input | 1 | Overflow pulse from the neighbouring timer |
| nbr_unf | input | 1 | Underflow pulse from the neighbouring timer |
| ovf | output | 1 | Registered overflow pulse |
| unf | output | 1 | Registered underflow pulse |

## Verification
A register write lands at its write edge, and a read shows the value one edge after the address is presented. External-input actions land two edges after the pin change is first clocked in. The wrap outputs rise at the edge that wraps the count. The bench drives all inputs on falling edges and samples on falling edges. It brackets every counting window with a start and a stop at known edges, so the final count is fixed before it is read back. It checks the wrap outputs at the exact sample that follows the predicted wrap edge.

// File: rtl/edge_timer_pkg.sv
package edge_timer_pkg;
  localparam int ADDR_CTRL = 'h00;
  localparam int ADDR_CMD  = 'h04;
  localparam int ADDR_TOP  = 'h08;
  localparam int ADDR_CNT  = 'h0C;
  localparam int ADDR_CFG  = 'h10;

  localparam logic [31:0] CTRL_MASK = 32'h0F03_0F00;
  localparam int DIV_LSB  = 24;
  localparam int SRC_LSB  = 16;
  localparam int FALL_LSB = 10;
  localparam int RISE_LSB = 8;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_START  = 2'd1,
    ACT_STOP   = 2'd2,
    ACT_RELOAD = 2'd3
  } edge_act_e;

  typedef enum logic [1:0] {
    SRC_DIV     = 2'd0,
    SRC_TICKIN  = 2'd1,
    SRC_CASCADE = 2'd2,
    SRC_ALT     = 2'd3
  } cnt_src_e;
endpackage

// File: rtl/et_sync_edge.sv
module et_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  assert_edge_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
  assert_fall_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/et_prescaler.sv
module et_prescaler #(
  parameter int PRE_W  = 10,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  // codes above PRE_W saturate: the mask simply runs out of bits
  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (int'(code_i) > i);
  end

  assign tick_o = ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr_i) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_o && code_i != '0) |=> (!tick_o || code_i == '0));
endmodule

// File: rtl/et_counter.sv
module et_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             down_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      if (start_i || reload_i) run_q <= 1'b1;
      else if (stop_i)         run_q <= 1'b0;
      if (cnt_wr_i) begin
        cnt_q <= cnt_wdata_i;
      end else if (reload_i) begin
        cnt_q <= down_i ? top_i : '0;
      end else if (run_q && tick_i) begin
        if (!down_i) begin
          if (cnt_q == top_i) begin
            cnt_q <= '0;
            ovf_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            cnt_q <= top_i;
            unf_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  assert_ovf_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt_q == '0));
  assert_unf_top_R10: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> (cnt_q == $past(top_i)));
  assert_wrap_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && unf_o));
  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (reload_i && !cnt_wr_i) |=> (run_q && cnt_q == $past(down_i ? top_i : {CNT_W{1'b0}})));
  assert_stop_R11: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i && !reload_i) |=> !run_q);
endmodule

// File: rtl/edge_timer.sv
module edge_timer
  import edge_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int PRE_W   = 10,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_in,
  input  logic              tick_in,
  input  logic              nbr_ovf,
  input  logic              nbr_unf,
  output logic              ovf,
  output logic              unf
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  top_q;
  logic              down_q;

  logic wr_ctrl, wr_cmd, wr_top, wr_cnt, wr_cfg;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign wr_cmd  = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));
  assign wr_top  = wr_en && (wr_addr == ADDR_W'(ADDR_TOP));
  assign wr_cnt  = wr_en && (wr_addr == ADDR_W'(ADDR_CNT));
  assign wr_cfg  = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      top_q  <= '1;
      down_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data & DATA_W'(CTRL_MASK);
      if (wr_top)  top_q  <= wr_data[CNT_W-1:0];
      if (wr_cfg)  down_q <= wr_data[0];
    end
  end

  logic [3:0] div_code;
  cnt_src_e   src;
  edge_act_e  rise_act, fall_act;
  assign div_code = ctrl_q[DIV_LSB +: 4];
  assign src      = cnt_src_e'(ctrl_q[SRC_LSB +: 2]);
  assign fall_act = edge_act_e'(ctrl_q[FALL_LSB +: 2]);
  assign rise_act = edge_act_e'(ctrl_q[RISE_LSB +: 2]);

  logic ext_rise, ext_fall, tin_rise, tin_fall_unused;
  et_sync_edge #(.STAGES(SYNC_ST)) u_ext_sync (
    .clk(clk), .rst(rst), .pin_i(ext_in), .rise_o(ext_rise), .fall_o(ext_fall));
  et_sync_edge #(.STAGES(SYNC_ST)) u_tick_sync (
    .clk(clk), .rst(rst), .pin_i(tick_in), .rise_o(tin_rise), .fall_o(tin_fall_unused));

  // arbitration: rising edge over falling edge over software command
  edge_act_e act;
  always_comb begin
    act = ACT_NONE;
    if (wr_cmd) begin
      if (wr_data[0])      act = ACT_START;
      else if (wr_data[1]) act = ACT_STOP;
    end
    if (ext_fall && fall_act != ACT_NONE) act = fall_act;
    if (ext_rise && rise_act != ACT_NONE) act = rise_act;
  end

  logic pre_clr, pre_tick;
  assign pre_clr = (act == ACT_START) || (act == ACT_RELOAD);

  et_prescaler #(.PRE_W(PRE_W), .CODE_W(4)) u_presc (
    .clk(clk), .rst(rst), .clr_i(pre_clr), .code_i(div_code), .tick_o(pre_tick));

  logic cnt_tick;
  always_comb begin
    case (src)
      SRC_TICKIN:  cnt_tick = tin_rise;
      SRC_CASCADE: cnt_tick = down_q ? nbr_unf : nbr_ovf;
      default:     cnt_tick = pre_tick;
    endcase
  end

  logic [CNT_W-1:0] cnt_val;
  logic             cnt_run;
  et_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .cnt_wr_i(wr_cnt), .cnt_wdata_i(wr_data[CNT_W-1:0]),
    .top_i(top_q), .down_i(down_q), .tick_i(cnt_tick),
    .start_i(act == ACT_START), .stop_i(act == ACT_STOP), .reload_i(act == ACT_RELOAD),
    .cnt_o(cnt_val), .run_o(cnt_run), .ovf_o(ovf), .unf_o(unf));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (int'(rd_addr))
        ADDR_CTRL: rd_data <= ctrl_q;
        ADDR_TOP:  rd_data <= {{PAD_W{1'b0}}, top_q};
        ADDR_CNT:  rd_data <= {{PAD_W{1'b0}}, cnt_val};
        ADDR_CFG:  rd_data <= {{(DATA_W-1){1'b0}}, down_q};
        default:   rd_data <= '0;
      endcase
    end
  end

  assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr == ADDR_W'(ADDR_CTRL)) |-> ((rd_data & ~DATA_W'(CTRL_MASK)) == '0));
  assert_edge_stop_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (ext_rise && rise_act == ACT_STOP) |=> !cnt_run);
  assert_edge_start_R6: assert property (@(posedge clk) disable iff (rst)
    (ext_rise && (rise_act == ACT_START || rise_act == ACT_RELOAD)) |=> cnt_run);
endmodule

// File: tb/edge_timer_tb.sv
module edge_timer_tb_top;
  import edge_timer_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ext_in = 1'b0, tick_in = 1'b0, nbr_ovf = 1'b0, nbr_unf = 1'b0;
  logic        ovf, unf;
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_in(ext_in), .tick_in(tick_in),
    .nbr_ovf(nbr_ovf), .nbr_unf(nbr_unf), .ovf(ovf), .unf(unf));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = 5'(a);
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [3:0] dv, input logic [1:0] sr,
                                          input logic [1:0] fa, input logic [1:0] ra);
    return {4'b0, dv, 6'b0, sr, 4'b0, fa, ra, 8'b0};
  endfunction

  function automatic int exp_div(input int n, input int code);
    int c = (code > 10) ? 10 : code;
    return n >> c;
  endfunction

  // run n edges between a command start and a command stop, return the count
  task automatic cmd_window(input int n, output logic [31:0] d);
    wr(ADDR_CMD, 32'h1);
    idle(n - 1);
    wr(ADDR_CMD, 32'h2);
    rd(ADDR_CNT, d);
  endtask

  // pin high for d cycles then low
  task automatic pin_window(input int d);
    ext_in = 1'b1; idle(d);
    ext_in = 1'b0; idle(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int no, nu;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(ADDR_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(ADDR_TOP, v);  chk("R1 top", v, 32'hFFFF);
    rd(ADDR_CNT, v);  chk("R1 cnt", v, 32'h0);
    chk("R1 wrap outs", {30'b0, ovf, unf}, 32'h0);
    idle(10);
    rd(ADDR_CNT, v);  chk("R1 stopped", v, 32'h0);

    // R2 register layout
    wr(ADDR_CTRL, 32'hFFFF_FFFF);
    rd(ADDR_CTRL, v); chk("R2 ctrl mask", v, 32'h0F03_0F00);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] r = $urandom;
      wr(ADDR_CTRL, r);
      rd(ADDR_CTRL, v); chk("R2 ctrl rand", v, r & 32'h0F03_0F00);
    end
    wr(ADDR_CTRL, 32'h0);
    wr(ADDR_CFG, 32'hFFFF_FFFF);
    rd(ADDR_CFG, v); chk("R2 cfg", v, 32'h1);
    wr(ADDR_CFG, 32'h0);
    wr(ADDR_TOP, 32'h1234_ABCD);
    rd(ADDR_TOP, v); chk("R2 top", v, 32'hABCD);
    wr(ADDR_TOP, 32'hFFFF);
    wr(ADDR_CNT, 32'h0000_0777);
    rd(ADDR_CNT, v); chk("R2 cnt", v, 32'h777);

    // R11 command start/stop keep count
    wr(ADDR_CNT, 32'd50);
    cmd_window(17, v); chk("R11 start stop", v, 32'd67);

    // R3 prescaler, directed then random
    wr(ADDR_CTRL, mk_ctrl(4'd10, 2'd0, 2'd0, 2'd0)); wr(ADDR_CNT, 0);
    cmd_window(2053, v); chk("R3 div1024", v, 32'(exp_div(2053, 10)));
    wr(ADDR_CTRL, mk_ctrl(4'd13, 2'd0, 2'd0, 2'd0)); wr(ADDR_CNT, 0);
    cmd_window(1030, v); chk("R3 code13 saturates", v, 32'(exp_div(1030, 13)));
    for (int i = 0; i < 10; i++) begin
      int code = int'($urandom % 16);
      int n = 1 + int'($urandom % 2500);
      logic [1:0] sr = ($urandom % 2 == 0) ? 2'd0 : 2'd3;
      wr(ADDR_CTRL, mk_ctrl(4'(code), sr, 2'd0, 2'd0)); wr(ADDR_CNT, 0);
      cmd_window(n, v); chk("R3 random div", v, 32'(exp_div(n, code)));
    end

    // R4 count input edges
    wr(ADDR_CTRL, mk_ctrl(4'd0, 2'd1, 2'd0, 2'd0)); wr(ADDR_CNT, 0);
    wr(ADDR_CMD, 32'h1);
    for (int i = 0; i < 7; i++) begin
      tick_in = 1'b1; idle(3); tick_in = 1'b0; idle(3);
    end
    wr(ADDR_CMD, 32'h2);
    rd(ADDR_CNT, v); chk("R4 tick edges", v, 32'd7);

    // R5 cascade, up then down
    wr(ADDR_CTRL, mk_ctrl(4'd0, 2'd2, 2'd0, 2'd0)); wr(ADDR_CNT, 0);
    wr(ADDR_CMD, 32'h1);
    for (int i = 0; i < 5; i++) begin
      nbr_ovf = 1'b1; idle(1); nbr_ovf = 1'b0; nbr_unf = 1'b1; idle(1); nbr_unf = 1'b0; idle(1);
    end
    wr(ADDR_CMD, 32'h2);
    rd(ADDR_CNT, v); chk("R5 cascade up", v, 32'd5);
    wr(ADDR_CFG, 32'h1); wr(ADDR_CNT, 32'd100);
    wr(ADDR_CMD, 32'h1);
    for (int i = 0; i < 6; i++) begin
      nbr_ovf = 1'b1; idle(1); nbr_ovf = 1'b0; nbr_unf = 1'b1; idle(1); nbr_unf = 1'b0; idle(1);
    end
    wr(ADDR_CMD, 32'h2);
    rd(ADDR_CNT, v); chk("R5 cascade down", v, 32'd94);
    wr(ADDR_CFG, 32'h0);

    // R6 start on rise, R7 stop on fall
    wr(ADDR_CTRL, mk_ctrl(4'd0, 2'd0, 2'd2, 2'd1)); wr(ADDR_CNT, 0);
    pin_window(11);
    rd(ADDR_CNT, v); chk("R6 R7 rise start fall stop", v, 32'd11);

    // R6 code 0 ignored, then R7 start on fall, R6 stop on rise
    wr(ADDR_CTRL, 32'h0); wr(ADDR_CNT, 0);
    ext_in = 1'b1; idle(6);
    rd(ADDR_CNT, v); chk("R6 none keeps count", v, 32'd0);
    idle(5);
    rd(ADDR_CNT, v); chk("R6 none stays stopped", v, 32'd0);
    wr(ADDR_CTRL, mk_ctrl(4'd0, 2'd0, 2'd1, 2'd2));
    ext_in = 1'b0; idle(8);
    ext_in = 1'b1; idle(6);
    rd(ADDR_CNT, v); chk("R7 fall start", v, 32'd8);
    ext_in = 1'b0; idle(6);
    wr(ADDR_CMD, 32'h2);

    // R8 reload up and down
    wr(ADDR_CTRL, mk_ctrl(4'd0, 2'd0, 2'd2, 2'd3)); wr(ADDR_CNT, 32'd500);
    pin_window(13);
    rd(ADDR_CNT, v); chk("R8 reload up", v, 32'd13);
    wr(ADDR_TOP, 32'd1000); wr(ADDR_CFG, 32'h1); wr(ADDR_CNT, 32'd5);
    pin_window(9);
    rd(ADDR_CNT, v); chk("R8 reload down", v, 32'd991);
    wr(ADDR_TOP, 32'hFFFF); wr(ADDR_CFG, 32'h0);

    // R9 edge stop beats command start in same cycle
    wr(ADDR_CTRL, mk_ctrl(4'd0, 2'd0, 2'd0, 2'd2)); wr(ADDR_CNT, 0);
    ext_in = 1'b1; idle(2);
    wr(ADDR_CMD, 32'h1);
    idle(8);
    rd(ADDR_CNT, v); chk("R9 edge over command", v, 32'd0);
    ext_in = 1'b0; idle(4);
    wr(ADDR_CTRL, 32'h0);

    // R10 wrap pulses
    wr(ADDR_TOP, 32'd3); wr(ADDR_CNT, 0);
    wr(ADDR_CMD, 32'h1);
    no = 0; nu = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 3) chk("R10 no early ovf", {31'b0, ovf}, 32'd0);
      if (i == 4) chk("R10 ovf at wrap", {31'b0, ovf}, 32'd1);
      no += int'(ovf); nu += int'(unf);
    end
    chk("R10 ovf count", 32'(no), 32'd10);
    chk("R10 no unf up", 32'(nu), 32'd0);
    wr(ADDR_CMD, 32'h2);
    wr(ADDR_CFG, 32'h1); wr(ADDR_CNT, 0);
    wr(ADDR_CMD, 32'h1);
    no = 0; nu = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 1) chk("R10 unf at wrap", {31'b0, unf}, 32'd1);
      no += int'(ovf); nu += int'(unf);
    end
    chk("R10 unf count", 32'(nu), 32'd10);
    chk("R10 no ovf down", 32'(no), 32'd0);
    wr(ADDR_CMD, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule